// File: doc/BRIEF.md
# Local Bus Chip-Select Controller

This block turns single-beat requests from an on-chip master into cycles on an external peripheral bus for one chip select. A request carries an address, write data, a transfer size and a read/write flag. It is accepted with a valid/ready handshake and answered by a one-cycle response pulse that carries read data, an error flag and a timeout flag. The controller checks the address against a programmable window and checks the access against the device's width and access permissions. It then either runs a bus cycle or rejects the request with an error, and a rejected request never touches the bus pins.

A bus cycle has an optional address-latch phase and a data phase. The address-latch phase is used when address and data share lanes. The data phase length comes from a programmable wait count. The wait count can be picked per direction from two 8-bit fields or taken as one 16-bit value. When the acknowledge input is enabled, the data phase can end early. In that mode the wait count becomes a timeout. Byte order can be reversed separately for writes and reads. Three registers on a simple register port hold the window, the device configuration and a global enable.

Top module: `lbus_cs_ctrl`

## Requirements
- R1: Register 0 holds the window. Bits 31..16 give the low bound as address bits 31..16, with the lower 16 bits taken as zero. Bits 15..0 give the high bound as address bits 31..16, with the lower 16 bits taken as ones. An address inside the closed range hits; any other address is rejected with an error.
- R2: Bit 24 of register 2 is a global enable, and bit 12 of register 1 is the chip-select enable. If either is clear, no bus cycle starts and the request is answered with an error. Registers stay readable and writable in that state.
- R3: The data phase lasts W+1 bus clocks. Register 1 bits 23..16 are field X and bits 31..24 are field P. The wait type in bits 5..4 sets W as follows. Code 0 uses X for both directions. Code 1 uses X for reads and P for writes. Code 2 uses X for reads and the 16-bit value {P,X} for writes. Code 3 uses {P,X} for both directions.
- R4: When bit 15 is set, an address phase of L+1 clocks precedes the data phase, where L is bits 11..10. During that phase the address is driven on the shared lanes and the latch strobe is at its active level. Bit 14 gives that level: 1 is high, 0 is low. When bit 15 is clear there is no address phase.
- R5: Register 1 bits 9..8 give the device width: 0 is 1 byte, 1 is 2 bytes, 3 is 4 bytes, and 2 is reserved. The request size uses the same codes. A reserved width, a reserved size, or a size wider than the device is rejected with an error.
- R6: Bit 0 of register 1 marks the device read-only and bit 1 marks it write-only. A write to a read-only device or a read from a write-only device is rejected with an error. A rejected request answers one clock after acceptance, with chip select left high.
- R7: When bit 13 is set, a high acknowledge sampled during the data phase ends it in that clock. If the count runs out with no acknowledge, the response carries both the timeout and error flags. When bit 13 is clear, acknowledge is ignored.
- R8: Bit 3 reverses the byte order of write data and bit 2 reverses the byte order of read data. The reversal covers the low bytes spanned by the request size, and the other bytes keep their positions.
- R9: Chip select is low through the address and data phases. Output enable is low only during the data phase of a read. The read/write line stays stable while chip select is low. In the clock after a cycle ends, chip select is high, the response is valid and ready is low; ready returns the clock after that.
- R10: Register 2 reads back only bit 24; its other bits read as zero. Registers 0 and 1 read back as written.
- R11: After reset, ready is high, no response is pending, chip select and output enable are high, and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 window, 1 config, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Request byte address |
| req_size | input | 2 | Transfer size code |
| req_wdata | input | 32 | Write data, low lanes first |
| rsp_valid | output | 1 | One-clock response strobe |
| rsp_err | output | 1 | Request rejected or timed out |
| rsp_timeout | output | 1 | Data phase ended by count with acknowledge enabled |
| rsp_rdata | output | 32 | Read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ale | output | 1 | Address latch strobe, programmable level |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_wr | output | 1 | 1 for a write cycle |
| bus_addr | output | 32 | Address for non-shared operation |
| bus_ad_o | output | 32 | Shared lanes, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_o |
| bus_ad_i | input | 32 | Shared lanes, incoming value |
| bus_ack | input | 1 | Device acknowledge, active high |

## Verification
The bound checker watches the pin protocol on every clock. It checks that output enable only appears in a read data phase, that the direction line holds while chip select is low, and that the latch phase never returns after the data phase has begun. It also checks that a rejected request answers at once without chip select, and that each cycle is followed by a response clock and then ready. Phase lengths cannot be checked that way, and neither can the choice among the four wait types, the window bounds, acknowledge against timeout or the byte reversal. Those depend on register contents, so the bench's scenarios establish them by counting pin cycles and comparing the data lanes and response fields with values it derives itself.

// File: rtl/lbus_cs_pkg.sv
package lbus_cs_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int WIN_W  = 16;
  localparam int WAIT_W = 8;
  localparam int CNT_W  = 2 * WAIT_W;
  localparam int LOW_W  = ADDR_W - WIN_W;
  localparam int NBYTE  = DATA_W / 8;
  localparam int ME_BIT = 24;

  localparam logic [1:0] REG_WIN = 2'd0;
  localparam logic [1:0] REG_CFG = 2'd1;
  localparam logic [1:0] REG_CTL = 2'd2;

  // Device configuration word, MSB first.
  typedef struct packed {
    logic [WAIT_W-1:0] wp;     // 31..24
    logic [WAIT_W-1:0] wx;     // 23..16
    logic              mux;    // 15
    logic              alev;   // 14
    logic              acken;  // 13
    logic              csen;   // 12
    logic [1:0]        alen;   // 11..10
    logic [1:0]        wid;    // 9..8
    logic [1:0]        rsv;    // 7..6
    logic [1:0]        wtyp;   // 5..4
    logic              wswap;  // 3
    logic              rswap;  // 2
    logic              wo;     // 1
    logic              ro;     // 0
  } cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ALE, ST_DATA, ST_RESP} seq_e;

  // Number of bytes for a width/size code; 0 marks the reserved code.
  function automatic int unsigned size_bytes(logic [1:0] code);
    int unsigned n;
    unique case (code)
      2'b00:   n = 1;
      2'b01:   n = 2;
      2'b11:   n = 4;
      default: n = 0;
    endcase
    return n;
  endfunction

  function automatic logic size_fits(logic [1:0] sz, logic [1:0] wid);
    return (size_bytes(sz) != 0) && (size_bytes(wid) != 0) &&
           (size_bytes(sz) <= size_bytes(wid));
  endfunction

  // Data-phase wait count selected by the wait type and direction.
  function automatic logic [CNT_W-1:0] wait_select(cfg_t c, logic wr);
    logic [CNT_W-1:0] x16, p16, px, r;
    x16 = CNT_W'(c.wx);
    p16 = CNT_W'(c.wp);
    px  = {c.wp, c.wx};
    unique case (c.wtyp)
      2'b00:   r = x16;
      2'b01:   r = wr ? p16 : x16;
      2'b10:   r = wr ? px  : x16;
      default: r = px;
    endcase
    return r;
  endfunction

  // Reverse the lowest size_bytes(sz) bytes, keep the rest in place.
  function automatic logic [DATA_W-1:0] swap_lanes(logic [DATA_W-1:0] d, logic [1:0] sz);
    logic [DATA_W-1:0] r;
    int unsigned n;
    n = size_bytes(sz);
    r = d;
    for (int i = 0; i < NBYTE; i++) begin
      if (i < int'(n)) r[8*i +: 8] = d[8*(int'(n)-1-i) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/lbus_cs_regs.sv
module lbus_cs_regs
  import lbus_cs_pkg::*;
#(
  parameter logic [2*WIN_W-1:0] WIN_RST = '0,
  parameter logic [DATA_W-1:0]  CFG_RST = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [2*WIN_W-1:0]  win_q,
  output cfg_t                cfg_q,
  output logic                me_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= WIN_RST;
      cfg_q <= cfg_t'(CFG_RST);
      me_q  <= 1'b0;
    end else if (reg_we) begin
      unique case (reg_addr)
        REG_WIN: win_q <= reg_wdata[2*WIN_W-1:0];
        REG_CFG: cfg_q <= cfg_t'(reg_wdata);
        REG_CTL: me_q  <= reg_wdata[ME_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_WIN: reg_rdata = DATA_W'(win_q);
      REG_CFG: reg_rdata = DATA_W'(cfg_q);
      REG_CTL: reg_rdata[ME_BIT] = me_q;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/lbus_cs_decode.sv
module lbus_cs_decode
  import lbus_cs_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr,
  input  logic                write,
  input  logic [1:0]          size,
  input  logic [2*WIN_W-1:0]  win,
  input  cfg_t                cfg,
  input  logic                me,
  output logic                hit,
  output logic                go
);

  logic [ADDR_W-1:0] lo_bound;
  logic [ADDR_W-1:0] hi_bound;
  logic              perm_ok;
  logic              fld_unused;

  assign lo_bound = {win[2*WIN_W-1:WIN_W], {LOW_W{1'b0}}};
  assign hi_bound = {win[WIN_W-1:0],       {LOW_W{1'b1}}};
  assign hit      = (addr >= lo_bound) && (addr <= hi_bound);
  assign perm_ok  = write ? !cfg.ro : !cfg.wo;
  assign go       = hit && me && cfg.csen && perm_ok && size_fits(size, cfg.wid);

  assign fld_unused = ^{cfg.wp, cfg.wx, cfg.mux, cfg.alev, cfg.acken, cfg.alen,
                        cfg.rsv, cfg.wtyp, cfg.wswap, cfg.rswap};

endmodule

// File: rtl/lbus_cs_seq.sv
module lbus_cs_seq
  import lbus_cs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                go,
  input  cfg_t                cfg,
  input  logic                bus_ack,
  input  logic [DATA_W-1:0]   bus_ad_i,
  output logic                req_ready,
  output logic                acc_fire,
  output logic                ale_on,
  output logic                data_on,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic                rsp_timeout,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                bus_cs_n,
  output logic                bus_ale,
  output logic                bus_oe_n,
  output logic                bus_wr,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_ad_o,
  output logic                bus_ad_oe
);

  seq_e              state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  wait_q;
  logic              wr_q, alev_q, acken_q, rswap_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q, to_q;
  logic              ack_hit, cnt_done, data_end;
  logic              fld_unused;

  assign acc_fire = (state == ST_IDLE) && req_valid;
  assign ale_on   = (state == ST_ALE);
  assign data_on  = (state == ST_DATA);
  assign ack_hit  = acken_q && bus_ack;
  assign cnt_done = (cnt == '0);
  assign data_end = data_on && (ack_hit || cnt_done);

  assign fld_unused = ^{cfg.csen, cfg.wid, cfg.rsv, cfg.wo, cfg.ro};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      wait_q  <= '0;
      wr_q    <= 1'b0;
      alev_q  <= 1'b0;
      acken_q <= 1'b0;
      rswap_q <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (acc_fire) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            size_q  <= req_size;
            wdata_q <= cfg.wswap ? swap_lanes(req_wdata, req_size) : req_wdata;
            to_q    <= 1'b0;
            if (go) begin
              err_q   <= 1'b0;
              alev_q  <= cfg.alev;
              acken_q <= cfg.acken;
              rswap_q <= cfg.rswap;
              wait_q  <= wait_select(cfg, req_write);
              if (cfg.mux) begin
                state <= ST_ALE;
                cnt   <= CNT_W'(cfg.alen);
              end else begin
                state <= ST_DATA;
                cnt   <= wait_select(cfg, req_write);
              end
            end else begin
              err_q <= 1'b1;
              state <= ST_RESP;
            end
          end
        end
        ST_ALE: begin
          if (cnt_done) begin
            state <= ST_DATA;
            cnt   <= wait_q;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_DATA: begin
          if (data_end) begin
            state   <= ST_RESP;
            rdata_q <= rswap_q ? swap_lanes(bus_ad_i, size_q) : bus_ad_i;
            to_q    <= acken_q && !bus_ack;
            err_q   <= acken_q && !bus_ack;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_RESP);
  assign rsp_err     = err_q;
  assign rsp_timeout = to_q;
  assign rsp_rdata   = rdata_q;

  assign bus_cs_n  = !(ale_on || data_on);
  assign bus_ale   = alev_q ? ale_on : !ale_on;
  assign bus_oe_n  = !(data_on && !wr_q);
  assign bus_wr    = wr_q;
  assign bus_addr  = addr_q;
  assign bus_ad_o  = ale_on ? DATA_W'(addr_q) : wdata_q;
  assign bus_ad_oe = ale_on || (data_on && wr_q);

endmodule

// File: rtl/lbus_cs_ctrl.sv
module lbus_cs_ctrl
  import lbus_cs_pkg::*;
#(
  parameter logic [2*WIN_W-1:0] WIN_RST = '0,
  parameter logic [DATA_W-1:0]  CFG_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [31:0]        req_addr,
  input  logic [1:0]         req_size,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic               rsp_timeout,
  output logic [31:0]        rsp_rdata,
  output logic               bus_cs_n,
  output logic               bus_ale,
  output logic               bus_oe_n,
  output logic               bus_wr,
  output logic [31:0]        bus_addr,
  output logic [31:0]        bus_ad_o,
  output logic               bus_ad_oe,
  input  logic [31:0]        bus_ad_i,
  input  logic               bus_ack
);

  logic [2*WIN_W-1:0] win_q;
  cfg_t               cfg_q;
  logic               me_q;
  logic               acc_hit;
  logic               acc_go;
  logic               acc_fire;
  logic               ale_on;
  logic               data_on;
  logic               hit_unused;

  lbus_cs_regs #(.WIN_RST(WIN_RST), .CFG_RST(CFG_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .win_q     (win_q),
    .cfg_q     (cfg_q),
    .me_q      (me_q)
  );

  lbus_cs_decode u_dec (
    .addr  (req_addr),
    .write (req_write),
    .size  (req_size),
    .win   (win_q),
    .cfg   (cfg_q),
    .me    (me_q),
    .hit   (acc_hit),
    .go    (acc_go)
  );

  assign hit_unused = acc_hit;

  lbus_cs_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .req_wdata   (req_wdata),
    .go          (acc_go),
    .cfg         (cfg_q),
    .bus_ack     (bus_ack),
    .bus_ad_i    (bus_ad_i),
    .req_ready   (req_ready),
    .acc_fire    (acc_fire),
    .ale_on      (ale_on),
    .data_on     (data_on),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_timeout (rsp_timeout),
    .rsp_rdata   (rsp_rdata),
    .bus_cs_n    (bus_cs_n),
    .bus_ale     (bus_ale),
    .bus_oe_n    (bus_oe_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_ad_o    (bus_ad_o),
    .bus_ad_oe   (bus_ad_oe)
  );

endmodule

// File: rtl/lbus_cs_chk.sv
module lbus_cs_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_err,
  input logic rsp_timeout,
  input logic bus_cs_n,
  input logic bus_oe_n,
  input logic bus_wr,
  input logic bus_ad_oe,
  input logic acc_fire,
  input logic acc_go,
  input logic ale_on,
  input logic data_on
);

  // R6 (also covers R1, R2, R5 rejections): answered next clock, no chip select
  a_r6_reject_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_go |=> bus_cs_n && rsp_valid && rsp_err);

  a_r9_oe_read_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> data_on && !bus_wr && !bus_cs_n);

  a_r9_rw_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n && !$past(bus_cs_n) |-> $stable(bus_wr));

  a_r9_gap_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> rsp_valid && !req_ready);

  a_r9_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready && !rsp_valid);

  a_r7_timeout_is_error: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_timeout |-> rsp_err);

  a_r4_ale_drives_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    ale_on |-> !bus_cs_n && bus_ad_oe);

  a_r4_no_ale_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    data_on |=> !ale_on);

endmodule

bind lbus_cs_ctrl lbus_cs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .rsp_timeout (rsp_timeout),
  .bus_cs_n    (bus_cs_n),
  .bus_oe_n    (bus_oe_n),
  .bus_wr      (bus_wr),
  .bus_ad_oe   (bus_ad_oe),
  .acc_fire    (acc_fire),
  .acc_go      (acc_go),
  .ale_on      (ale_on),
  .data_on     (data_on)
);

// File: tb/tb_lbus_cs_ctrl.sv
module tb_lbus_cs_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, rsp_timeout;
  logic [31:0] rsp_rdata;
  logic        bus_cs_n, bus_ale, bus_oe_n, bus_wr, bus_ad_oe;
  logic [31:0] bus_addr, bus_ad_o;
  logic [31:0] bus_ad_i = '0;
  logic        bus_ack = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] sh_win = '0;
  logic [31:0] sh_cfg = '0;
  logic        sh_me  = 1'b0;

  always #5 clk = ~clk;

  lbus_cs_ctrl dut (.*);

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      2'd3: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] flip(logic [31:0] d, logic [1:0] sz);
    logic [7:0] b [4];
    logic [7:0] t [4];
    int n;
    n = nbytes(sz);
    for (int i = 0; i < 4; i++) b[i] = d[8*i +: 8];
    for (int i = 0; i < 4; i++) t[i] = (i < n) ? b[n-1-i] : b[i];
    return {t[3], t[2], t[1], t[0]};
  endfunction

  function automatic int exp_wait(logic [31:0] c, bit wr);
    int p, x;
    p = int'(c[31:24]);
    x = int'(c[23:16]);
    case (c[5:4])
      2'd0: return x;
      2'd1: return wr ? p : x;
      2'd2: return wr ? (p * 256 + x) : x;
      default: return p * 256 + x;
    endcase
  endfunction

  function automatic bit exp_go(bit wr, logic [31:0] a, logic [1:0] sz);
    bit in_win, size_ok, perm_ok;
    in_win  = (a[31:16] >= sh_win[31:16]) && (a[31:16] <= sh_win[15:0]);
    size_ok = (nbytes(sz) > 0) && (nbytes(sh_cfg[9:8]) > 0) &&
              (nbytes(sz) <= nbytes(sh_cfg[9:8]));
    perm_ok = wr ? !sh_cfg[0] : !sh_cfg[1];
    return in_win && sh_me && sh_cfg[12] && size_ok && perm_ok;
  endfunction

  function automatic logic [31:0] mk_cfg(int p, int x, bit mux, bit alev, bit acken, bit ce,
                                         int alen, int wid, int wtyp, bit ws, bit rs, bit wo, bit ro);
    return {8'(p), 8'(x), mux, alev, acken, ce, 2'(alen), 2'(wid), 2'b00, 2'(wtyp), ws, rs, wo, ro};
  endfunction

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      2'd0: sh_win = d;
      2'd1: sh_cfg = d;
      2'd2: sh_me  = d[24];
      default: ;
    endcase
  endtask

  task automatic rreg(logic [1:0] a, logic [31:0] exp, string what);
    reg_addr = a;
    #1;
    check(reg_rdata === exp, what, reg_rdata, exp);
  endtask

  task automatic access(bit wr, logic [31:0] a, logic [1:0] sz, logic [31:0] wd,
                        logic [31:0] rd, int ack_k);
    bit go, to, alev, ale_act;
    int w, n_ale, n_data, cs_cnt, ale_cnt, didx, bad_ad, bad_oe, guard;
    logic [31:0] lane_w;
    go    = exp_go(wr, a, sz);
    w     = exp_wait(sh_cfg, wr);
    alev  = sh_cfg[14];
    n_ale = (go && sh_cfg[15]) ? int'(sh_cfg[11:10]) + 1 : 0;
    to    = 1'b0;
    if (!go) n_data = 0;
    else if (sh_cfg[13] && ack_k >= 0 && ack_k <= w) n_data = ack_k + 1;
    else begin
      n_data = w + 1;
      to = sh_cfg[13];
    end
    lane_w = sh_cfg[3] ? flip(wd, sz) : wd;
    bus_ad_i  = rd;
    req_write = wr;
    req_addr  = a;
    req_size  = sz;
    req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cs_cnt = 0; ale_cnt = 0; didx = 0; bad_ad = 0; bad_oe = 0; guard = 0;
    while (!rsp_valid && guard < 2000) begin
      bus_ack = 1'b0;
      if (!bus_cs_n) begin
        cs_cnt++;
        ale_act = (bus_ale == alev);
        if (ale_act) begin
          ale_cnt++;
          if (!bus_ad_oe || bus_ad_o !== a) bad_ad++;
        end else begin
          if (wr && (!bus_ad_oe || bus_ad_o !== lane_w)) bad_ad++;
          if (wr == !bus_oe_n) bad_oe++;
          bus_ack = (didx == ack_k);
          didx++;
        end
      end
      @(negedge clk);
      guard++;
    end
    bus_ack = 1'b0;
    check(cs_cnt == n_ale + n_data, "R3 R7 R6 chip-select cycle count", 32'(cs_cnt), 32'(n_ale + n_data));
    check(ale_cnt == n_ale, "R4 latch phase length", 32'(ale_cnt), 32'(n_ale));
    check(rsp_valid && rsp_err == (!go || to), "R1 R2 R5 R6 error flag",
          {30'b0, rsp_valid, rsp_err}, {30'b0, 1'b1, (!go || to)});
    check(rsp_timeout == to, "R7 timeout flag", 32'(rsp_timeout), 32'(to));
    check(bad_ad == 0, "R4 R8 shared-lane contents", 32'(bad_ad), 32'd0);
    check(bad_oe == 0, "R9 output enable phase", 32'(bad_oe), 32'd0);
    if (go && !wr && !to)
      check(rsp_rdata === (sh_cfg[2] ? flip(rd, sz) : rd), "R8 read data",
            rsp_rdata, sh_cfg[2] ? flip(rd, sz) : rd);
    check(!req_ready && bus_cs_n, "R9 response clock", {30'b0, req_ready, bus_cs_n}, 32'd1);
    @(negedge clk);
    check(req_ready && !rsp_valid, "R9 ready after response", {30'b0, req_ready, rsp_valid}, 32'd2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(req_ready && !rsp_valid && bus_cs_n && bus_oe_n, "R11 reset outputs",
          {28'b0, req_ready, rsp_valid, bus_cs_n, bus_oe_n}, 32'hB);
    rreg(2'd0, 32'h0, "R11 window reset");
    rreg(2'd1, 32'h0, "R11 config reset");
    rreg(2'd2, 32'h0, "R11 control reset");

    // R10 readback
    wreg(2'd2, 32'hFFFF_FFFF);
    rreg(2'd2, 32'h0100_0000, "R10 control readback");
    wreg(2'd0, 32'h1000_10FF);
    rreg(2'd0, 32'h1000_10FF, "R10 window readback");
    wreg(2'd1, mk_cfg(0, 2, 0, 0, 0, 1, 0, 3, 0, 0, 0, 0, 0));
    rreg(2'd1, mk_cfg(0, 2, 0, 0, 0, 1, 0, 3, 0, 0, 0, 0, 0), "R10 config readback");

    // R1 window edges
    access(0, 32'h1000_0000, 2'd3, 32'h0, 32'hA1B2_C3D4, -1);
    access(1, 32'h10FF_FFFF, 2'd3, 32'h1122_3344, 32'h0, -1);
    access(0, 32'h0FFF_FFFF, 2'd3, 32'h0, 32'h0, -1);
    access(0, 32'h1100_0000, 2'd3, 32'h0, 32'h0, -1);

    // R2 global and chip-select enables
    wreg(2'd2, 32'h0);
    access(0, 32'h1000_0040, 2'd0, 32'h0, 32'h5A, -1);
    wreg(2'd2, 32'h0100_0000);
    wreg(2'd1, mk_cfg(0, 2, 0, 0, 0, 0, 0, 3, 0, 0, 0, 0, 0));
    access(1, 32'h1000_0040, 2'd0, 32'h77, 32'h0, -1);

    // R5 width and size
    wreg(2'd1, mk_cfg(0, 1, 0, 0, 0, 1, 0, 2, 0, 0, 0, 0, 0));
    access(0, 32'h1000_0000, 2'd0, 32'h0, 32'h12, -1);
    wreg(2'd1, mk_cfg(0, 1, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0));
    access(0, 32'h1000_0000, 2'd3, 32'h0, 32'h12, -1);
    access(0, 32'h1000_0000, 2'd1, 32'h0, 32'h1234, -1);
    access(0, 32'h1000_0000, 2'd2, 32'h0, 32'h1234, -1);

    // R6 permissions
    wreg(2'd1, mk_cfg(1, 1, 0, 0, 0, 1, 0, 3, 1, 0, 0, 0, 1));
    access(1, 32'h1000_0010, 2'd3, 32'hDEAD_BEEF, 32'h0, -1);
    access(0, 32'h1000_0010, 2'd3, 32'h0, 32'hCAFE_F00D, -1);
    wreg(2'd1, mk_cfg(1, 1, 0, 0, 0, 1, 0, 3, 1, 0, 0, 1, 0));
    access(0, 32'h1000_0010, 2'd3, 32'h0, 32'hCAFE_F00D, -1);
    access(1, 32'h1000_0010, 2'd3, 32'hDEAD_BEEF, 32'h0, -1);

    // R7 acknowledge and timeout
    wreg(2'd1, mk_cfg(0, 3, 0, 0, 1, 1, 0, 3, 0, 0, 0, 0, 0));
    access(0, 32'h1000_0100, 2'd3, 32'h0, 32'h0101_0202, 0);
    access(0, 32'h1000_0100, 2'd3, 32'h0, 32'h0303_0404, 3);
    access(0, 32'h1000_0100, 2'd3, 32'h0, 32'h0, -1);
    access(1, 32'h1000_0100, 2'd3, 32'h55, 32'h0, 5);
    wreg(2'd1, mk_cfg(0, 3, 0, 0, 0, 1, 0, 3, 0, 0, 0, 0, 0));
    access(0, 32'h1000_0100, 2'd3, 32'h0, 32'h0505_0606, 0);

    // R4 multiplexed address phase, both strobe levels
    wreg(2'd1, mk_cfg(0, 1, 1, 1, 0, 1, 3, 3, 0, 0, 0, 0, 0));
    access(1, 32'h1000_2468, 2'd3, 32'h89AB_CDEF, 32'h0, -1);
    wreg(2'd1, mk_cfg(0, 0, 1, 0, 0, 1, 0, 3, 0, 0, 0, 0, 0));
    access(0, 32'h1000_1357, 2'd3, 32'h0, 32'h2468_ACE0, -1);

    // R8 byte reversal
    wreg(2'd1, mk_cfg(0, 1, 0, 0, 0, 1, 0, 3, 0, 1, 1, 0, 0));
    access(1, 32'h1000_0000, 2'd3, 32'h0102_0304, 32'h0, -1);
    access(1, 32'h1000_0000, 2'd1, 32'hAABB_CCDD, 32'h0, -1);
    access(0, 32'h1000_0000, 2'd1, 32'h0, 32'h1122_3344, -1);
    access(0, 32'h1000_0000, 2'd3, 32'h0, 32'h1122_3344, -1);

    // R3 long 16-bit count
    wreg(2'd1, mk_cfg(1, 2, 0, 0, 0, 1, 0, 3, 3, 0, 0, 0, 0));
    access(0, 32'h1000_0000, 2'd3, 32'h0, 32'h0F0F_0F0F, -1);

    // random mix of configurations and requests
    for (int it = 0; it < 150; it++) begin
      logic [31:0] c;
      logic [31:0] addr;
      c = mk_cfg(int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 7) != 0), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0));
      wreg(2'd1, c);
      wreg(2'd2, ($urandom_range(0, 9) != 0) ? 32'h0100_0000 : 32'h0);
      addr = {16'($urandom_range(32'h0FFF, 32'h1100)), 16'($urandom)};
      access(1'($urandom_range(0, 1)), addr, 2'($urandom_range(0, 3)), $urandom, $urandom,
             int'($urandom_range(0, 6)) - 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule